// File: doc/BRIEF.md
# Primary Packet Field CRC-32 Unit

This unit generates and verifies the 32-bit cyclic redundancy check that guards each protected field of a primary packet on a serial bus: the header of an asynchronous or isochronous packet, and the data payload that follows it. A field arrives as a stream of 32-bit quadlets, one quadlet per clock, with a start-of-field marker on the first quadlet and an end-of-field marker on the last. Header and payload are separate fields, so each gets its own CRC pass and its own CRC quadlet.

In generate mode the field quadlets are streamed in, and one cycle after the last one the unit presents the CRC quadlet to be appended. In check mode the received CRC quadlet follows the field quadlets and carries the end-of-field marker itself; one cycle later the unit reports pass or fail. A field-kind input, sampled with the start marker, states whether the field is an asynchronous header (three or four quadlets), an isochronous header (one quadlet) or payload, so the unit can also flag a header whose length is wrong.

Top module: `pkt_crc32_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, crc_valid, chk_valid, chk_pass and len_err are 0 and crc_out is 0.
- R2: In generate mode, one cycle after an accepted quadlet with in_eof set, crc_valid is 1 and crc_out is the bitwise complement of the remainder of the division by polynomial 0x04C11DB7, with the register preset to all ones and every field quadlet (the end-marked one included) shifted in most significant bit first.
- R3: A quadlet with in_sof set restarts the register at all ones, so a field's result never depends on any earlier field, even one abandoned without an end marker.
- R4: In check mode the end-marked quadlet is the received CRC and is not divided; one cycle later chk_valid is 1 and chk_pass is 1 exactly when that quadlet equals the complemented remainder of the preceding quadlets of the field.
- R5: in_kind encodes 00 payload, 01 isochronous header (1 quadlet), 10 asynchronous header (3 quadlets), 11 asynchronous header (4 quadlets); len_err is 1 together with the result pulse when a header field's quadlet count (not counting a trailing received CRC) differs from that length, and is never 1 for payload.
- R6: Cycles with in_valid low have no effect: they change no result and produce no result pulse.
- R7: crc_valid and chk_valid are never 1 together, are 1 only in the cycle after an accepted end-marked quadlet, and crc_out changes only in such a cycle.
- R8: in_check and in_kind are taken only with in_sof; changes on them during the rest of the field have no effect on that field's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Quadlet on in_quad is accepted this cycle |
| in_sof | input | 1 | First quadlet of a field |
| in_eof | input | 1 | Last quadlet of a field (the received CRC in check mode) |
| in_check | input | 1 | 1 = check mode, 0 = generate mode (taken with in_sof) |
| in_kind | input | 2 | Field kind (taken with in_sof), encoding per R5 |
| in_quad | input | 32 | Quadlet, most significant bit first |
| crc_valid | output | 1 | Generated CRC available on crc_out |
| crc_out | output | 32 | Generated (or expected) CRC quadlet |
| chk_valid | output | 1 | Check result available |
| chk_pass | output | 1 | Received CRC matched |
| len_err | output | 1 | Header field length wrong |

## Verification
Random fields of every kind and both modes are streamed with random quadlet values, which separates a correct polynomial, preset, bit order and final complement from near misses. Check-mode fields carry either the right CRC or one with a single flipped bit, telling a real comparison from one stuck at pass. Header lengths are mostly correct but sometimes one short or one long, idle cycles with junk on the data lines are slipped between quadlets, and mode and kind are scrambled after the start marker, so length checking, gap handling and start-only sampling are each exposed. A directed abandoned field followed by a fresh one shows that the start marker restarts the register.

// File: rtl/pkt_crc_pkg.sv
package pkt_crc_pkg;

    localparam int unsigned QUAD_W = 32;
    localparam logic [QUAD_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [QUAD_W-1:0] CRC_PRESET = '1;

    typedef enum logic [1:0] {
        FK_PAYLOAD  = 2'b00,
        FK_ISO_HDR  = 2'b01,
        FK_ASY_HDR3 = 2'b10,
        FK_ASY_HDR4 = 2'b11
    } field_kind_e;

    typedef struct packed {
        logic        is_check;
        field_kind_e kind;
    } field_ctx_t;

    typedef struct packed {
        logic              gen_done;
        logic              chk_done;
        logic              pass;
        logic              len_bad;
        logic [QUAD_W-1:0] crc;
    } crc_result_t;

    // One quadlet through the divider, most significant bit first.
    function automatic logic [QUAD_W-1:0] crc_step(input logic [QUAD_W-1:0] cur,
                                                   input logic [QUAD_W-1:0] quad);
        logic [QUAD_W-1:0] c;
        logic              fb;
        c = cur;
        for (int i = QUAD_W - 1; i >= 0; i--) begin
            fb = c[QUAD_W-1] ^ quad[i];
            c  = {c[QUAD_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

    // Expected quadlet count of a header kind (payload has none).
    function automatic logic [2:0] hdr_quads(input field_kind_e k);
        case (k)
            FK_ISO_HDR:  return 3'd1;
            FK_ASY_HDR3: return 3'd3;
            FK_ASY_HDR4: return 3'd4;
            default:     return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/fld_ctx_latch.sv
module fld_ctx_latch
    import pkt_crc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  logic       sof,
    input  field_ctx_t ctx_in,
    output field_ctx_t ctx_eff
);
    field_ctx_t ctx_q;

    assign ctx_eff = sof ? ctx_in : ctx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '{is_check: 1'b0, kind: FK_PAYLOAD};
        end else if (valid && sof) begin
            ctx_q <= ctx_in;
        end
    end
endmodule

// File: rtl/crc32_lane.sv
module crc32_lane
    import pkt_crc_pkg::*;
#(
    parameter int unsigned W = QUAD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid,
    input  logic         sof,
    input  logic         feed,
    input  logic [W-1:0] quad,
    output logic [W-1:0] base,
    output logic [W-1:0] next
);
    logic [W-1:0] crc_q;

    assign base = sof ? CRC_PRESET : crc_q;
    assign next = crc_step(base, quad);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_PRESET;
        end else if (valid) begin
            if (feed) begin
                crc_q <= next;
            end else if (sof) begin
                crc_q <= CRC_PRESET;
            end
        end
    end
endmodule

// File: rtl/fld_len_meter.sv
module fld_len_meter
    import pkt_crc_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        valid,
    input  logic        sof,
    input  logic        feed,
    input  field_kind_e kind,
    output logic        len_bad
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] start_cnt;
    logic [CNT_W-1:0] fed_cnt;

    assign start_cnt = sof ? '0 : cnt_q;
    assign fed_cnt   = (start_cnt == CNT_MAX) ? CNT_MAX : start_cnt + CNT_W'(feed);
    assign len_bad   = (kind != FK_PAYLOAD) && (fed_cnt != CNT_W'(hdr_quads(kind)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (valid) begin
            cnt_q <= fed_cnt;
        end
    end
endmodule

// File: rtl/crc_result_reg.sv
module crc_result_reg
    import pkt_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              is_check,
    input  logic              len_bad,
    input  logic [QUAD_W-1:0] rx_quad,
    input  logic [QUAD_W-1:0] base,
    input  logic [QUAD_W-1:0] next,
    output crc_result_t       res
);
    logic [QUAD_W-1:0] expect_crc;

    assign expect_crc = is_check ? ~base : ~next;

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res.gen_done <= fire && !is_check;
            res.chk_done <= fire && is_check;
            res.pass     <= fire && is_check && (rx_quad == expect_crc);
            res.len_bad  <= fire && len_bad;
            if (fire) begin
                res.crc <= expect_crc;
            end
        end
    end
endmodule

// File: rtl/pkt_crc32_unit.sv
module pkt_crc32_unit
    import pkt_crc_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic        in_check,
    input  logic [1:0]  in_kind,
    input  logic [31:0] in_quad,
    output logic        crc_valid,
    output logic [31:0] crc_out,
    output logic        chk_valid,
    output logic        chk_pass,
    output logic        len_err
);
    field_ctx_t        ctx_in;
    field_ctx_t        ctx;
    logic              feed;
    logic              fire;
    logic              len_bad;
    logic [QUAD_W-1:0] base;
    logic [QUAD_W-1:0] next;
    crc_result_t       res;

    assign ctx_in.is_check = in_check;
    assign ctx_in.kind     = field_kind_e'(in_kind);

    // In check mode the end-marked quadlet is the received CRC.
    assign feed = in_valid && !(ctx.is_check && in_eof);
    assign fire = in_valid && in_eof;

    fld_ctx_latch u_ctx (
        .clk(clk), .rst(rst), .valid(in_valid), .sof(in_sof),
        .ctx_in(ctx_in), .ctx_eff(ctx)
    );

    crc32_lane #(.W(QUAD_W)) u_lane (
        .clk(clk), .rst(rst), .valid(in_valid), .sof(in_sof), .feed(feed),
        .quad(in_quad), .base(base), .next(next)
    );

    fld_len_meter #(.CNT_W(CNT_W)) u_len (
        .clk(clk), .rst(rst), .valid(in_valid), .sof(in_sof), .feed(feed),
        .kind(ctx.kind), .len_bad(len_bad)
    );

    crc_result_reg u_res (
        .clk(clk), .rst(rst), .fire(fire), .is_check(ctx.is_check),
        .len_bad(len_bad), .rx_quad(in_quad), .base(base), .next(next), .res(res)
    );

    assign crc_valid = res.gen_done;
    assign chk_valid = res.chk_done;
    assign chk_pass  = res.pass;
    assign len_err   = res.len_bad;
    assign crc_out   = res.crc;
endmodule

// File: rtl/pkt_crc32_chk.sv
module pkt_crc32_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_eof,
    input logic        crc_valid,
    input logic        chk_valid,
    input logic        chk_pass,
    input logic        len_err,
    input logic [31:0] crc_out
);
    // R7: the two result pulses never coincide
    p_excl_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        !(crc_valid && chk_valid));

    // R7: a result pulse only follows an accepted end-marked quadlet
    p_pulse_cause_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid == 1'b0 || in_eof == 1'b0) |=> !crc_valid && !chk_valid);

    // R6: an idle cycle yields no result
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !crc_valid && !chk_valid && !len_err);

    // R7: crc_out holds unless a field ended
    p_crc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_eof) |=> $stable(crc_out));

    // R4: pass only comes with a check result
    p_pass_qual_r4: assert property (@(posedge clk) disable iff (rst)
        chk_pass |-> chk_valid);

    // R5: length flag only with a result pulse
    p_len_qual_r5: assert property (@(posedge clk) disable iff (rst)
        len_err |-> (crc_valid || chk_valid));
endmodule

bind pkt_crc32_unit pkt_crc32_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_eof(in_eof),
    .crc_valid(crc_valid), .chk_valid(chk_valid), .chk_pass(chk_pass),
    .len_err(len_err), .crc_out(crc_out)
);

// File: tb/sim_pkt_crc32_unit.sv
module sim_pkt_crc32_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sof, in_eof, in_check;
    logic [1:0]  in_kind;
    logic [31:0] in_quad;
    logic        crc_valid, chk_valid, chk_pass, len_err;
    logic [31:0] crc_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] fq [0:7];

    always #5 clk = ~clk;

    pkt_crc32_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_check(in_check), .in_kind(in_kind),
        .in_quad(in_quad), .crc_valid(crc_valid), .crc_out(crc_out),
        .chk_valid(chk_valid), .chk_pass(chk_pass), .len_err(len_err)
    );

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int q = 0; q < n; q++) begin
            for (int b = 31; b >= 0; b--) begin
                if (r[31] != fq[q][b]) r = (r << 1) ^ 32'h04C1_1DB7;
                else                   r = r << 1;
            end
        end
        return ~r;
    endfunction

    function automatic int kind_len(input logic [1:0] k);
        return (k == 2'b01) ? 1 : (k == 2'b10) ? 3 : (k == 2'b11) ? 4 : 0;
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle; outputs seen here come from the previous edge.
    task automatic put(input bit v, input bit s, input bit e, input bit c,
                       input logic [1:0] k, input logic [31:0] q, input bit quiet);
        @(negedge clk);
        if (quiet) cmp("R7 no pulse mid-field", {30'd0, crc_valid, chk_valid}, 32'd0);
        in_valid = v; in_sof = s; in_eof = e; in_check = c; in_kind = k; in_quad = q;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_quad = $urandom;
    endtask

    task automatic run_field(input logic [1:0] k, input bit chk, input int n,
                             input bit corrupt, input bit gaps);
        int total;
        logic [31:0] crc;
        logic [31:0] q;
        bit exp_len;
        for (int i = 0; i < n; i++) fq[i] = $urandom;
        crc = ref_crc(n);
        total = chk ? n + 1 : n;
        for (int i = 0; i < total; i++) begin
            bit first = (i == 0);
            bit last  = (i == total - 1);
            if (gaps && !first && ($urandom % 4 == 0)) begin
                // R6: idle cycle with junk markers and data
                put(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), $urandom, 1'b1);
            end
            q = (i < n) ? fq[i] : (corrupt ? crc ^ (32'd1 << ($urandom % 32)) : crc);
            if (first) put(1'b1, 1'b1, last, chk, k, q, 1'b0);
            else       put(1'b1, 1'b0, last, 1'($urandom), 2'($urandom), q, 1'b1); // R8 junk
        end
        idle();
        exp_len = (k != 2'b00) && (n != kind_len(k));
        if (chk) begin
            cmp("R4 chk_valid", {31'd0, chk_valid}, 32'd1);
            cmp("R7 crc_valid low in check", {31'd0, crc_valid}, 32'd0);
            cmp("R4 chk_pass", {31'd0, chk_pass}, {31'd0, !corrupt});
        end else begin
            cmp("R2 crc_valid", {31'd0, crc_valid}, 32'd1);
            cmp("R7 chk_valid low in generate", {31'd0, chk_valid}, 32'd0);
            cmp("R2 crc_out", crc_out, crc);
        end
        cmp("R5 len_err", {31'd0, len_err}, {31'd0, exp_len});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 0; in_sof = 0; in_eof = 0; in_check = 0;
        in_kind = 0; in_quad = 0;
        repeat (3) @(negedge clk);
        cmp("R1 reset outputs", {28'd0, crc_valid, chk_valid, chk_pass, len_err}, 32'd0);
        cmp("R1 reset crc_out", crc_out, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        cmp("R1 after reset", {28'd0, crc_valid, chk_valid, chk_pass, len_err}, 32'd0);

        // Directed corners
        run_field(2'b01, 1'b0, 1, 1'b0, 1'b0);   // R2 one-quadlet iso header
        run_field(2'b01, 1'b1, 1, 1'b0, 1'b0);   // R4 iso header check pass
        run_field(2'b10, 1'b0, 3, 1'b0, 1'b0);   // R2 async header 3
        run_field(2'b11, 1'b1, 4, 1'b1, 1'b0);   // R4 corrupted CRC fails
        run_field(2'b11, 1'b0, 3, 1'b0, 1'b0);   // R5 short async header
        run_field(2'b10, 1'b1, 4, 1'b0, 1'b0);   // R5 long async header
        run_field(2'b00, 1'b0, 7, 1'b0, 1'b1);   // R6 payload with gaps
        // R3: abandoned field then fresh one
        put(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, $urandom, 1'b0);
        put(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, $urandom, 1'b1);
        run_field(2'b00, 1'b0, 2, 1'b0, 1'b0);   // R3 restart at start marker
        run_field(2'b00, 1'b1, 5, 1'b0, 1'b0);   // R3 header-then-data independence

        // Constrained random
        for (int t = 0; t < 400; t++) begin
            logic [1:0] k = 2'($urandom);
            bit chk = 1'($urandom);
            int n;
            if (k == 2'b00) n = 1 + ($urandom % 8);
            else begin
                n = kind_len(k);
                if ($urandom % 5 == 0) n = ($urandom % 2 == 0) ? n + 1 : n - 1;
                if (n < 1) n = 2;
            end
            run_field(k, chk, n, ($urandom % 4 == 0), 1'($urandom));
            if ($urandom % 3 == 0) idle();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule